// File: doc/BRIEF.md
# Post-Modify Circular Address Generator

This block produces operand addresses for a signal processor datapath. It holds four address pointers and four modify registers. Each pointer also has a length and a base. When an access is strobed, the chosen pointer's present value is issued as the address. The pointer then advances by the signed contents of a modify register, and any of the four modify registers can be paired with any pointer.

A pointer whose length is zero steps linearly and rolls over at the top of the 14-bit space. A nonzero length L turns the pointer into a circular buffer. The window starts at the base, which is captured whenever the pointer is written, and ends at base+L-1. A step that leaves the window is folded back into it by adding or subtracting L once. Folding is correct only while the magnitude of the step stays below L.

Software-visible state is written through three independent write ports: pointer, length and modify. A pointer write arriving in the same cycle as an access to that pointer overrides the post-modify result.

Top module: `circ_agen`

## Requirements
- R1: After reset, all pointers, bases, lengths and modify registers are zero, and `addr_vld` is low.
- R2: An access strobe in cycle n makes `addr_vld` high in cycle n+1, with `addr_out` equal to the selected pointer's value before the update. Without a strobe, `addr_vld` is low in the next cycle.
- R3: With length zero, the pointer becomes (pointer + modify) mod 2^14 after an access.
- R4: Modify values are 14-bit two's complement. For example, 0x3FFF steps the pointer back by one.
- R5: Any pointer select (0..3) can be combined with any modify select (0..3), and an access changes only the selected pointer.
- R6: With a nonzero length L, a post-modified result at or above base+L is reduced by L.
- R7: With a nonzero length L, a post-modified result below base is increased by L.
- R8: A pointer write in the same cycle as an access to that pointer sets the pointer to the written value and not to the post-modified one. The access still issues the old value.
- R9: A pointer write sets both the pointer and its base to the written value. A length write leaves the pointer unchanged.
- R10: A pointer that is neither written nor accessed keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ptr_wr_en | input | 1 | Pointer write strobe |
| ptr_wr_sel | input | 2 | Pointer to write |
| ptr_wr_val | input | 14 | New pointer value, also the base |
| len_wr_en | input | 1 | Length write strobe |
| len_wr_sel | input | 2 | Pointer whose length is written |
| len_wr_val | input | 14 | New length (0 = linear) |
| mod_wr_en | input | 1 | Modify register write strobe |
| mod_wr_sel | input | 2 | Modify register to write |
| mod_wr_val | input | 14 | Signed modify value |
| acc_en | input | 1 | Indirect access strobe |
| acc_ptr_sel | input | 2 | Pointer used by the access |
| acc_mod_sel | input | 2 | Modify register used by the access |
| addr_out | output | 14 | Issued address |
| addr_vld | output | 1 | Address valid, one cycle per access |

## Verification
A corrupted pointer, base or length produces no symptom until that pointer is accessed again. The bad value then appears on `addr_out` one cycle after that later strobe. The bench therefore follows every update with another access through an all-zero modify register, which exposes the stored pointer without moving it. A wrong fold decision shows as an address lying outside the window, or as a value differing by exactly L from the expected one. Circular sequences are run through both fold directions until each direction has wrapped at least once.

// File: rtl/circ_agen_pkg.sv
package circ_agen_pkg;
    localparam int ADDR_W_DEF = 14;
    localparam int NPTR_DEF   = 4;
    localparam int NMOD_DEF   = 4;
endpackage

// File: rtl/circ_agen_wrap.sv
// Post-modify adder with single fold into [base, base+len).
module circ_agen_wrap #(
    parameter int AW = 14
) (
    input  logic [AW-1:0] cur_ptr,
    input  logic [AW-1:0] step,
    input  logic [AW-1:0] win_base,
    input  logic [AW-1:0] win_len,
    output logic [AW-1:0] nxt_ptr
);
    localparam int SW = AW + 2;

    logic signed [SW-1:0] sum_s;
    logic signed [SW-1:0] lo_s;
    logic signed [SW-1:0] hi_s;
    logic signed [SW-1:0] len_s;

    always_comb begin
        sum_s = signed'({2'b00, cur_ptr}) + signed'({{2{step[AW-1]}}, step});
        lo_s  = signed'({2'b00, win_base});
        len_s = signed'({2'b00, win_len});
        hi_s  = lo_s + len_s;
        nxt_ptr = AW'(sum_s);
        if (win_len != '0) begin
            if (sum_s >= hi_s) begin
                nxt_ptr = AW'(sum_s - len_s);
            end else if (sum_s < lo_s) begin
                nxt_ptr = AW'(sum_s + len_s);
            end
        end
    end
endmodule

// File: rtl/circ_agen_mod_bank.sv
module circ_agen_mod_bank #(
    parameter int AW   = 14,
    parameter int NMOD = 4,
    parameter int MW   = $clog2(NMOD)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [MW-1:0] wr_sel,
    input  logic [AW-1:0] wr_val,
    input  logic [MW-1:0] rd_sel,
    output logic [AW-1:0] rd_val
);
    logic [NMOD-1:0][AW-1:0] mod_d, mod_q;

    always_comb begin
        mod_d = mod_q;
        if (wr_en) begin
            mod_d[wr_sel] = wr_val;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mod_q <= '0;
        end else begin
            mod_q <= mod_d;
        end
    end

    assign rd_val = mod_q[rd_sel];

    // R5: a written modify value is what later accesses see
    p_mod_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> mod_q[$past(wr_sel)] == $past(wr_val));
endmodule

// File: rtl/circ_agen_ptr_bank.sv
module circ_agen_ptr_bank #(
    parameter int AW   = 14,
    parameter int NPTR = 4,
    parameter int PW   = $clog2(NPTR)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ptr_wr_en,
    input  logic [PW-1:0] ptr_wr_sel,
    input  logic [AW-1:0] ptr_wr_val,
    input  logic          len_wr_en,
    input  logic [PW-1:0] len_wr_sel,
    input  logic [AW-1:0] len_wr_val,
    input  logic          acc_en,
    input  logic [PW-1:0] acc_sel,
    input  logic [AW-1:0] upd_ptr,
    input  logic          step_small,
    output logic [AW-1:0] rd_ptr,
    output logic [AW-1:0] rd_base,
    output logic [AW-1:0] rd_len
);
    typedef struct packed {
        logic [AW-1:0] ptr;
        logic [AW-1:0] base;
        logic [AW-1:0] len;
    } ent_t;

    ent_t [NPTR-1:0] ent_d, ent_q;

    always_comb begin
        ent_d = ent_q;
        for (int k = 0; k < NPTR; k++) begin
            if (acc_en && acc_sel == PW'(k)) begin
                ent_d[k].ptr = upd_ptr;
            end
            if (len_wr_en && len_wr_sel == PW'(k)) begin
                ent_d[k].len = len_wr_val;
            end
            // write after update: the load wins
            if (ptr_wr_en && ptr_wr_sel == PW'(k)) begin
                ent_d[k].ptr  = ptr_wr_val;
                ent_d[k].base = ptr_wr_val;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_q <= '0;
        end else begin
            ent_q <= ent_d;
        end
    end

    assign rd_ptr  = ent_q[acc_sel].ptr;
    assign rd_base = ent_q[acc_sel].base;
    assign rd_len  = ent_q[acc_sel].len;

    function automatic logic in_win(logic [AW-1:0] p, logic [AW-1:0] b,
                                    logic [AW-1:0] l);
        return ({1'b0, p} >= {1'b0, b}) && ({1'b0, p} < ({1'b0, b} + {1'b0, l}));
    endfunction

    for (genvar k = 0; k < NPTR; k++) begin : g_chk
        // R8: pointer write has priority over post-modify
        p_load_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (ptr_wr_en && ptr_wr_sel == PW'(k)) |=> ent_q[k].ptr == $past(ptr_wr_val));
        // R10: untouched pointer holds
        p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (!(ptr_wr_en && ptr_wr_sel == PW'(k)) && !(acc_en && acc_sel == PW'(k)))
            |=> $stable(ent_q[k].ptr));
        // R6/R7: an in-window pointer stays in its window after a small step
        p_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (acc_en && acc_sel == PW'(k) && step_small && ent_q[k].len != '0
             && !(ptr_wr_en && ptr_wr_sel == PW'(k))
             && !(len_wr_en && len_wr_sel == PW'(k))
             && in_win(ent_q[k].ptr, ent_q[k].base, ent_q[k].len))
            |=> in_win(ent_q[k].ptr, ent_q[k].base, ent_q[k].len));
    end
endmodule

// File: rtl/circ_agen.sv
module circ_agen #(
    parameter int AW   = circ_agen_pkg::ADDR_W_DEF,
    parameter int NPTR = circ_agen_pkg::NPTR_DEF,
    parameter int NMOD = circ_agen_pkg::NMOD_DEF,
    localparam int PW  = $clog2(NPTR),
    localparam int MW  = $clog2(NMOD)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ptr_wr_en,
    input  logic [PW-1:0] ptr_wr_sel,
    input  logic [AW-1:0] ptr_wr_val,
    input  logic          len_wr_en,
    input  logic [PW-1:0] len_wr_sel,
    input  logic [AW-1:0] len_wr_val,
    input  logic          mod_wr_en,
    input  logic [MW-1:0] mod_wr_sel,
    input  logic [AW-1:0] mod_wr_val,
    input  logic          acc_en,
    input  logic [PW-1:0] acc_ptr_sel,
    input  logic [MW-1:0] acc_mod_sel,
    output logic [AW-1:0] addr_out,
    output logic          addr_vld
);
    typedef struct packed {
        logic          vld;
        logic [AW-1:0] addr;
    } out_t;

    out_t          out_d, out_q;
    logic [AW-1:0] cur_ptr, cur_base, cur_len, cur_mod, nxt_ptr, step_mag;
    logic          step_small;

    circ_agen_mod_bank #(.AW(AW), .NMOD(NMOD), .MW(MW)) u_mods (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (mod_wr_en),
        .wr_sel (mod_wr_sel),
        .wr_val (mod_wr_val),
        .rd_sel (acc_mod_sel),
        .rd_val (cur_mod)
    );

    circ_agen_ptr_bank #(.AW(AW), .NPTR(NPTR), .PW(PW)) u_ptrs (
        .clk        (clk),
        .rst_n      (rst_n),
        .ptr_wr_en  (ptr_wr_en),
        .ptr_wr_sel (ptr_wr_sel),
        .ptr_wr_val (ptr_wr_val),
        .len_wr_en  (len_wr_en),
        .len_wr_sel (len_wr_sel),
        .len_wr_val (len_wr_val),
        .acc_en     (acc_en),
        .acc_sel    (acc_ptr_sel),
        .upd_ptr    (nxt_ptr),
        .step_small (step_small),
        .rd_ptr     (cur_ptr),
        .rd_base    (cur_base),
        .rd_len     (cur_len)
    );

    circ_agen_wrap #(.AW(AW)) u_wrap (
        .cur_ptr  (cur_ptr),
        .step     (cur_mod),
        .win_base (cur_base),
        .win_len  (cur_len),
        .nxt_ptr  (nxt_ptr)
    );

    always_comb begin
        step_mag   = cur_mod[AW-1] ? (~cur_mod + AW'(1)) : cur_mod;
        step_small = step_mag < cur_len;
        out_d.vld  = acc_en;
        out_d.addr = acc_en ? cur_ptr : out_q.addr;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign addr_out = out_q.addr;
    assign addr_vld = out_q.vld;

    // R2: issued address is the pre-update pointer
    p_issue_old_r2: assert property (@(posedge clk) disable iff (!rst_n)
        acc_en |=> addr_vld && addr_out == $past(cur_ptr));
    // R2: no strobe, no valid
    p_vld_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_en |=> !addr_vld);
endmodule

// File: tb/circ_agen_tb_top.sv
`timescale 1ns/1ps
module circ_agen_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        ptr_wr_en, len_wr_en, mod_wr_en, acc_en;
    logic [1:0]  ptr_wr_sel, len_wr_sel, mod_wr_sel, acc_ptr_sel, acc_mod_sel;
    logic [13:0] ptr_wr_val, len_wr_val, mod_wr_val;
    logic [13:0] addr_out;
    logic        addr_vld;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic [13:0] m_ptr [4];
    logic [13:0] m_base[4];
    logic [13:0] m_len [4];
    logic [13:0] m_mod [4];

    always #4 clk = ~clk;

    circ_agen dut_i (
        .clk(clk), .rst_n(rst_n),
        .ptr_wr_en(ptr_wr_en), .ptr_wr_sel(ptr_wr_sel), .ptr_wr_val(ptr_wr_val),
        .len_wr_en(len_wr_en), .len_wr_sel(len_wr_sel), .len_wr_val(len_wr_val),
        .mod_wr_en(mod_wr_en), .mod_wr_sel(mod_wr_sel), .mod_wr_val(mod_wr_val),
        .acc_en(acc_en), .acc_ptr_sel(acc_ptr_sel), .acc_mod_sel(acc_mod_sel),
        .addr_out(addr_out), .addr_vld(addr_vld)
    );

    function automatic logic [13:0] step_ref(logic [13:0] p, logic [13:0] m,
                                             logic [13:0] b, logic [13:0] l);
        int s;
        s = int'(p) + (m[13] ? int'(m) - 16384 : int'(m));
        if (l != 0) begin
            if (s >= int'(b) + int'(l)) s = s - int'(l);
            else if (s < int'(b)) s = s + int'(l);
        end
        return 14'(s);
    endfunction

    task automatic chk(string req, logic [13:0] act, logic [13:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        ptr_wr_en = 0; len_wr_en = 0; mod_wr_en = 0; acc_en = 0;
        ptr_wr_sel = 0; len_wr_sel = 0; mod_wr_sel = 0;
        acc_ptr_sel = 0; acc_mod_sel = 0;
        ptr_wr_val = 0; len_wr_val = 0; mod_wr_val = 0;
    endtask

    task automatic wr_ptr(int p, logic [13:0] v);
        @(negedge clk);
        ptr_wr_en = 1; ptr_wr_sel = 2'(p); ptr_wr_val = v;
        @(negedge clk);
        ptr_wr_en = 0;
        m_ptr[p] = v; m_base[p] = v;
    endtask

    task automatic wr_len(int p, logic [13:0] v);
        @(negedge clk);
        len_wr_en = 1; len_wr_sel = 2'(p); len_wr_val = v;
        @(negedge clk);
        len_wr_en = 0;
        m_len[p] = v;
    endtask

    task automatic wr_mod(int m, logic [13:0] v);
        @(negedge clk);
        mod_wr_en = 1; mod_wr_sel = 2'(m); mod_wr_val = v;
        @(negedge clk);
        mod_wr_en = 0;
        m_mod[m] = v;
    endtask

    // access: address appears one cycle after the strobe
    task automatic access(int p, int m, string req);
        @(negedge clk);
        acc_en = 1; acc_ptr_sel = 2'(p); acc_mod_sel = 2'(m);
        @(negedge clk);
        acc_en = 0;
        chk({req, " vld"}, 14'(addr_vld), 14'd1);
        chk(req, addr_out, m_ptr[p]);
        m_ptr[p] = step_ref(m_ptr[p], m_mod[m], m_base[p], m_len[p]);
    endtask

    // modify register 3 is never written, so it stays zero: a non-moving peek
    task automatic peek(int p, string req);
        access(p, 3, req);
    endtask

    task automatic t_reset();
        rst_n = 0;
        idle_inputs();
        repeat (3) @(negedge clk);
        chk("R1 vld after reset", 14'(addr_vld), 14'd0);
        chk("R1 addr after reset", addr_out, 14'd0);
        rst_n = 1;
        for (int k = 0; k < 4; k++) peek(k, "R1 pointer zero");
    endtask

    task automatic t_linear();
        wr_ptr(0, 14'd100);
        wr_mod(0, 14'd5);
        access(0, 0, "R3 first");
        access(0, 0, "R3 second");
        access(0, 0, "R3 third");
        peek(0, "R3 after steps");
        wr_mod(1, 14'h3FFF);
        access(0, 1, "R4 back one");
        peek(0, "R4 after back step");
        wr_ptr(1, 14'h3FFE);
        access(1, 0, "R3 near top");
        peek(1, "R3 rollover");
        wr_ptr(1, 14'd2);
        wr_mod(2, 14'h3FFB);
        access(1, 2, "R4 below zero");
        peek(1, "R4 rollunder");
    endtask

    task automatic t_cross();
        wr_ptr(2, 14'd1000);
        access(2, 1, "R5 p2 with m1");
        access(2, 0, "R5 p2 with m0");
        peek(0, "R5 p0 untouched");
        peek(2, "R5 p2 result");
    endtask

    task automatic t_circ_up();
        wr_ptr(2, 14'd200);
        wr_len(2, 14'd10);
        peek(2, "R9 length write keeps pointer");
        wr_mod(2, 14'd3);
        for (int i = 0; i < 6; i++) access(2, 2, "R6 upward wrap");
        peek(2, "R6 final");
    endtask

    task automatic t_circ_down();
        wr_ptr(3, 14'd50);
        wr_len(3, 14'd6);
        wr_mod(1, 14'h3FFC);
        for (int i = 0; i < 5; i++) access(3, 1, "R7 downward wrap");
        peek(3, "R7 final");
    endtask

    task automatic t_rebase();
        wr_ptr(3, 14'd500);
        peek(3, "R9 new base pointer");
        access(3, 1, "R9 step from new base");
        peek(3, "R9 wrap into new window");
    endtask

    task automatic t_load_prio();
        logic [13:0] old;
        old = m_ptr[0];
        @(negedge clk);
        acc_en = 1; acc_ptr_sel = 2'd0; acc_mod_sel = 2'd0;
        ptr_wr_en = 1; ptr_wr_sel = 2'd0; ptr_wr_val = 14'd777;
        @(negedge clk);
        acc_en = 0; ptr_wr_en = 0;
        chk("R8 old address issued", addr_out, old);
        m_ptr[0] = 14'd777; m_base[0] = 14'd777;
        peek(0, "R8 load wins");
    endtask

    task automatic t_idle();
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk("R2 idle no vld", 14'(addr_vld), 14'd0);
        end
        peek(1, "R10 p1 held");
        peek(2, "R10 p2 held");
    endtask

    initial begin
        for (int k = 0; k < 4; k++) begin
            m_ptr[k] = 0; m_base[k] = 0; m_len[k] = 0; m_mod[k] = 0;
        end
        t_reset();
        t_linear();
        t_cross();
        t_circ_up();
        t_circ_down();
        t_rebase();
        t_load_prio();
        t_idle();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule